// File: doc/BRIEF.md
# Streaming RGB-to-Luminance Pixel Pipeline

This block sits in a video path and takes one 24-bit RGB pixel per clock, along with horizontal sync, vertical sync and a data-enable flag. It works out an 8-bit luminance value in fixed point, using a weighted sum whose weights add up to 1024. A per-frame mode then selects what leaves the block. The choices are the luminance itself, its negative, a two-level image cut at a programmable threshold, or the untouched input pixel. In the three luminance modes the same 8-bit value drives all three colour channels.

The pipeline is three registers deep. The three control flags travel through a matching three-stage delay, so every output pixel lines up with its own sync and enable. Mode, threshold and rounding choice are read only at the start of a frame, which is the rising edge of the vertical sync input. A frame is therefore processed under one setting from start to end.

Top module: `gray_pix_pipe`

## Requirements
- R1: With rounding off, the luminance Y equals floor((306*R + 601*G + 117*B) / 1024). R is pix_i[23:16], G is pix_i[15:8] and B is pix_i[7:0].
- R2: With rounding on, Y is the value from R1 plus one whenever bit 9 of the weighted sum is 1. Full white still gives 255.
- R3: With mode 1 (negative), each output channel equals 255 - Y.
- R4: With mode 2 (two-level), each output channel is 255 when Y is strictly greater than the latched threshold, and 0 otherwise. Y equal to the threshold gives 0.
- R5: With mode 3 (pass-through), pix_o equals the input pixel unchanged.
- R6: With mode 0 (luminance), all three output channels carry Y. In every mode other than 3, the output channels pix_o[23:16], pix_o[15:8] and pix_o[7:0] hold the same value.
- R7: A pixel sampled at clock edge k appears on pix_o after edge k+2, a latency of three clocks. It is not yet present after edge k+1.
- R8: hs_o, vs_o and de_o equal hs_i, vs_i and de_i delayed by exactly three clocks.
- R9: Whenever de_o is 0, pix_o is 0, whatever the pixel value was at the input.
- R10: mode_i, thr_i and rnd_i are captured only at a clock edge where vs_i is 1 and was 0 at the previous edge. Changes at any other time do not affect the output.
- R11: A synchronous active-high rst clears pix_o, hs_o, vs_o and de_o. It also restores the settings to mode 0, threshold 140 and rounding off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_i | input | 24 | Input pixel, R high byte, B low byte |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in; its rising edge latches the settings |
| de_i | input | 1 | Data enable in |
| mode_i | input | 2 | 0 luminance, 1 negative, 2 two-level, 3 pass-through |
| thr_i | input | 8 | Threshold for the two-level mode |
| rnd_i | input | 1 | 1 = round the luminance to nearest |
| pix_o | output | 24 | Processed pixel |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |

## Verification
Some properties are checked by assertions on every clock:
- the three-clock alignment of the sync and enable outputs;
- zero pixels while enable is low;
- equal channels outside pass-through;
- only the levels 0 and 255 in two-level mode;
- settings that stay unchanged between frame starts.

Other behaviour only the bench scenarios can show: the exact luminance arithmetic, the rounding cases, the exact threshold boundary, ignoring settings that change mid-frame, and the defaults restored by reset. The bench drives stimulus vectors and directed cases for these and compares each result against a model built from the requirements.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

    // Output selection, latched once per frame
    typedef enum logic [1:0] {
        MODE_GRAY = 2'd0,
        MODE_INV  = 2'd1,
        MODE_BIN  = 2'd2,
        MODE_PASS = 2'd3
    } tone_mode_e;

    localparam int unsigned LAT = 3;   // data-path depth in clocks

endpackage

// File: rtl/gpp_sync_delay.sv
module gpp_sync_delay #(
    parameter int unsigned W     = 3,
    parameter int unsigned DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] sig_o
);

    logic [W-1:0] tap_d [DEPTH];
    logic [W-1:0] tap_q [DEPTH];

    always_comb begin
        tap_d[0] = sig_i;
        for (int i = 1; i < DEPTH; i++) begin
            tap_d[i] = tap_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) tap_q[g] <= '0;
                else     tap_q[g] <= tap_d[g];
            end
        end
    endgenerate

    assign sig_o = tap_q[DEPTH-1];

endmodule

// File: rtl/gpp_luma.sv
module gpp_luma #(
    parameter int unsigned CH_W = 8,
    parameter int unsigned FRAC = 10,
    parameter int unsigned KR   = 306,
    parameter int unsigned KG   = 601,
    parameter int unsigned KB   = 117
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3*CH_W-1:0] rgb_i,
    input  logic              de_i,
    input  logic              rnd_i,
    output logic [CH_W-1:0]   gray_o,
    output logic [3*CH_W-1:0] rgb_o,
    output logic              de_o
);

    localparam int unsigned ACC_W = CH_W + FRAC;
    localparam int unsigned PIX_W = 3 * CH_W;

    typedef struct packed {
        logic [ACC_W-1:0] pr;
        logic [ACC_W-1:0] pg;
        logic [ACC_W-1:0] pb;
        logic [PIX_W-1:0] rgb;
        logic             de;
    } mul_st_t;

    typedef struct packed {
        logic [CH_W-1:0]  gray;
        logic [PIX_W-1:0] rgb;
        logic             de;
    } sum_st_t;

    mul_st_t m_d, m_q;
    sum_st_t s_d, s_q;

    logic [ACC_W-1:0] sum_w;
    logic [CH_W-1:0]  trunc_w;
    logic             bump_w;

    always_comb begin
        // stage 1: three weighted products
        m_d.pr  = ACC_W'(KR) * ACC_W'(rgb_i[PIX_W-1 -: CH_W]);
        m_d.pg  = ACC_W'(KG) * ACC_W'(rgb_i[2*CH_W-1 -: CH_W]);
        m_d.pb  = ACC_W'(KB) * ACC_W'(rgb_i[CH_W-1:0]);
        m_d.rgb = rgb_i;
        m_d.de  = de_i;

        // stage 2: sum, truncate, optional round-to-nearest
        sum_w   = m_q.pr + m_q.pg + m_q.pb;
        trunc_w = sum_w[ACC_W-1:FRAC];
        bump_w  = rnd_i & sum_w[FRAC-1];
        s_d.gray = trunc_w + CH_W'(bump_w);
        s_d.rgb  = m_q.rgb;
        s_d.de   = m_q.de;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
            s_q <= '0;
        end else begin
            m_q <= m_d;
            s_q <= s_d;
        end
    end

    assign gray_o = s_q.gray;
    assign rgb_o  = s_q.rgb;
    assign de_o   = s_q.de;

    // R2: rounding never wraps full white back to zero
    a_r2_round_no_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(m_q.pr + m_q.pg + m_q.pb) == {CH_W{1'b1}} << FRAC) |-> (gray_o == {CH_W{1'b1}}));

endmodule

// File: rtl/gpp_tone.sv
module gpp_tone
    import gpp_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_W-1:0]   gray_i,
    input  logic [3*CH_W-1:0] rgb_i,
    input  logic              de_i,
    input  tone_mode_e        mode_i,
    input  logic [CH_W-1:0]   thr_i,
    output logic [3*CH_W-1:0] pix_o
);

    localparam int unsigned PIX_W = 3 * CH_W;

    logic [CH_W-1:0]  lvl_w;
    logic [PIX_W-1:0] pix_d, pix_q;

    always_comb begin
        unique case (mode_i)
            MODE_INV: lvl_w = ~gray_i;
            MODE_BIN: lvl_w = (gray_i > thr_i) ? {CH_W{1'b1}} : {CH_W{1'b0}};
            default:  lvl_w = gray_i;
        endcase
        if (!de_i)                   pix_d = '0;
        else if (mode_i == MODE_PASS) pix_d = rgb_i;
        else                         pix_d = {3{lvl_w}};
    end

    always_ff @(posedge clk) begin
        if (rst) pix_q <= '0;
        else     pix_q <= pix_d;
    end

    assign pix_o = pix_q;

    // R6: replicated channels outside pass-through
    a_r6_equal_channels: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) != MODE_PASS) |->
        (pix_o[PIX_W-1 -: CH_W] == pix_o[2*CH_W-1 -: CH_W] &&
         pix_o[2*CH_W-1 -: CH_W] == pix_o[CH_W-1:0]));

    // R4: two-level mode yields only full black or full white
    a_r4_two_levels: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MODE_BIN) |->
        (pix_o[CH_W-1:0] == '0 || pix_o[CH_W-1:0] == {CH_W{1'b1}}));

    // R3: negative of the stage-2 luminance
    a_r3_negative: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == MODE_INV && $past(de_i)) |->
        (pix_o[CH_W-1:0] == CH_W'({CH_W{1'b1}} - $past(gray_i))));

endmodule

// File: rtl/gray_pix_pipe.sv
module gray_pix_pipe
    import gpp_pkg::*;
#(
    parameter int unsigned CH_W    = 8,
    parameter int unsigned FRAC    = 10,
    parameter int unsigned THR_RST = 140
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3*CH_W-1:0] pix_i,
    input  logic              hs_i,
    input  logic              vs_i,
    input  logic              de_i,
    input  logic [1:0]        mode_i,
    input  logic [CH_W-1:0]   thr_i,
    input  logic              rnd_i,
    output logic [3*CH_W-1:0] pix_o,
    output logic              hs_o,
    output logic              vs_o,
    output logic              de_o
);

    localparam int unsigned PIX_W = 3 * CH_W;

    typedef struct packed {
        tone_mode_e      mode;
        logic [CH_W-1:0] thr;
        logic            rnd;
        logic            vs_prev;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d         = cfg_q;
        cfg_d.vs_prev = vs_i;
        if (vs_i && !cfg_q.vs_prev) begin
            cfg_d.mode = tone_mode_e'(mode_i);
            cfg_d.thr  = thr_i;
            cfg_d.rnd  = rnd_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode    <= MODE_GRAY;
            cfg_q.thr     <= CH_W'(THR_RST);
            cfg_q.rnd     <= 1'b0;
            cfg_q.vs_prev <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [CH_W-1:0]  gray_w;
    logic [PIX_W-1:0] rgb_w;
    logic             de_w;

    gpp_luma #(.CH_W(CH_W), .FRAC(FRAC)) u_luma (
        .clk    (clk),
        .rst    (rst),
        .rgb_i  (pix_i),
        .de_i   (de_i),
        .rnd_i  (cfg_q.rnd),
        .gray_o (gray_w),
        .rgb_o  (rgb_w),
        .de_o   (de_w)
    );

    gpp_tone #(.CH_W(CH_W)) u_tone (
        .clk    (clk),
        .rst    (rst),
        .gray_i (gray_w),
        .rgb_i  (rgb_w),
        .de_i   (de_w),
        .mode_i (cfg_q.mode),
        .thr_i  (cfg_q.thr),
        .pix_o  (pix_o)
    );

    gpp_sync_delay #(.W(3), .DEPTH(LAT)) u_ctl_dly (
        .clk   (clk),
        .rst   (rst),
        .sig_i ({hs_i, vs_i, de_i}),
        .sig_o ({hs_o, vs_o, de_o})
    );

    // cycles since reset, saturating at LAT, for the alignment check
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                  age_q <= '0;
        else if (age_q != 2'(LAT)) age_q <= age_q + 2'd1;
    end

    // R8: control flags are the inputs three clocks earlier
    a_r8_ctl_align: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'(LAT)) |-> ({hs_o, vs_o, de_o} == $past({hs_i, vs_i, de_i}, 3)));

    // R9: blanked pixel while enable is low
    a_r9_blank_zero: assert property (@(posedge clk) disable iff (rst)
        !de_o |-> (pix_o == '0));

    // R10: settings hold between frame starts
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !(vs_i && !cfg_q.vs_prev) |=>
        ($stable(cfg_q.mode) && $stable(cfg_q.thr) && $stable(cfg_q.rnd)));

endmodule

// File: tb/gray_pix_pipe_tb.sv
`timescale 1ns/1ps
module gray_pix_pipe_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pix_i = '0;
    logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [7:0]  thr_i = 8'd0;
    logic        rnd_i = 1'b0;
    logic [23:0] pix_o;
    logic        hs_o, vs_o, de_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gray_pix_pipe dut_i (
        .clk(clk), .rst(rst), .pix_i(pix_i), .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i),
        .mode_i(mode_i), .thr_i(thr_i), .rnd_i(rnd_i),
        .pix_o(pix_o), .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o)
    );

    // {mode[1:0], rnd, thr[7:0], rgb[23:0]}; expected comes from model()
    localparam int NV = 14;
    localparam logic [34:0] VECS [0:NV-1] = '{
        {2'd0, 1'b0, 8'd140, 24'hFF0000},
        {2'd0, 1'b1, 8'd140, 24'h00FF00},
        {2'd0, 1'b0, 8'd140, 24'h00FF00},
        {2'd0, 1'b0, 8'd140, 24'hFFFFFF},
        {2'd0, 1'b1, 8'd140, 24'hFFFFFF},
        {2'd1, 1'b0, 8'd10,  24'h3C7A19},
        {2'd1, 1'b1, 8'd10,  24'h00FF00},
        {2'd2, 1'b0, 8'd140, 24'h8C8C8C},
        {2'd2, 1'b0, 8'd140, 24'h8D8D8D},
        {2'd2, 1'b0, 8'd0,   24'h000000},
        {2'd2, 1'b0, 8'd254, 24'hFFFFFF},
        {2'd3, 1'b0, 8'd0,   24'hA1B2C3},
        {2'd3, 1'b1, 8'd0,   24'h0055FF},
        {2'd0, 1'b1, 8'd0,   24'h123456}
    };

    function automatic logic [23:0] model(input logic [1:0] m, input logic rnd,
                                          input logic [7:0] thr, input logic [23:0] p);
        int s, y;
        logic [7:0] v;
        s = 306 * p[23:16] + 601 * p[15:8] + 117 * p[7:0];
        y = s / 1024;
        if (rnd && (s % 1024) >= 512) y = y + 1;
        case (m)
            2'd1:    v = 8'(255 - y);
            2'd2:    v = (y > thr) ? 8'd255 : 8'd0;
            2'd3:    return p;
            default: v = 8'(y);
        endcase
        return {v, v, v};
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic rnd);
        case (m)
            2'd1:    return "R3";
            2'd2:    return "R4";
            2'd3:    return "R5";
            default: return rnd ? "R2" : "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // frame start: apply settings with a vs_i rising edge, then scramble the inputs
    task automatic frame_cfg(input logic [1:0] m, input logic rnd, input logic [7:0] thr);
        @(negedge clk);
        mode_i = m; rnd_i = rnd; thr_i = thr; vs_i = 1'b1;
        @(negedge clk);
        vs_i = 1'b0;
        mode_i = ~m; rnd_i = ~rnd; thr_i = ~thr;   // R10: must be ignored
    endtask

    // one pixel, then look two and three clocks later
    task automatic send(input logic [23:0] p, input logic de, input logic [23:0] exp,
                        input string tag);
        @(negedge clk);
        pix_i = p; de_i = de;
        @(negedge clk);
        pix_i = '0; de_i = 1'b0;
        @(negedge clk);
        chk("R7 early", {23'd0, de_o}, 24'd0);
        @(negedge clk);
        chk(tag, pix_o, exp);
        chk("R8 de", {23'd0, de_o}, {23'd0, de});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 pix", pix_o, 24'd0);
        chk("R11 ctl", {21'd0, hs_o, vs_o, de_o}, 24'd0);
        rst = 1'b0;

        // R11: default mode is luminance without any frame start
        mode_i = 2'd3;
        send(24'h406080, 1'b1, model(2'd0, 1'b0, 8'd140, 24'h406080), "R11 default");

        // main vector table: R1..R6, R10 (inputs scrambled after latch)
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  m;
            logic        r;
            logic [7:0]  t;
            logic [23:0] p;
            {m, r, t, p} = VECS[i];
            frame_cfg(m, r, t);
            send(p, 1'b1, model(m, r, t, p), tag_of(m, r));
        end

        // R6: channel replication in luminance mode for a colour pixel
        frame_cfg(2'd0, 1'b0, 8'd0);
        send(24'hC81E64, 1'b1, model(2'd0, 1'b0, 8'd0, 24'hC81E64), "R6");

        // R10: mid-frame mode change without a vs_i edge is ignored
        @(negedge clk);
        mode_i = 2'd3;
        send(24'h0A0B0C, 1'b1, model(2'd0, 1'b0, 8'd0, 24'h0A0B0C), "R10 midframe");

        // R9: enable low blanks the pixel even in pass-through
        frame_cfg(2'd3, 1'b0, 8'd0);
        send(24'hFFFFFF, 1'b0, 24'd0, "R9");

        // R8: hsync and vsync delayed three clocks
        @(negedge clk);
        hs_i = 1'b1; vs_i = 1'b1; mode_i = 2'd3;
        @(negedge clk);
        hs_i = 1'b0; vs_i = 1'b0;
        @(negedge clk);
        chk("R8 early", {22'd0, hs_o, vs_o}, 24'd0);
        @(negedge clk);
        chk("R8 sync", {22'd0, hs_o, vs_o}, 24'd3);
        @(negedge clk);
        chk("R8 after", {22'd0, hs_o, vs_o}, 24'd0);

        // R11: reset mid-run restores luminance mode
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 clear", pix_o, 24'd0);
        rst = 1'b0;
        mode_i = 2'd3;
        send(24'h102030, 1'b1, model(2'd0, 1'b0, 8'd140, 24'h102030), "R11 restore");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule